// File: doc/BRIEF.md
# First-Come First-Served Channel Arbiter

This block decides which of up to twelve channels may use a single shared transmit engine. Each channel raises a level request when it has a packet to send. The arbiter records the clock edge at which every request was first seen. Whenever the engine is free, it grants the channel whose request has waited longest. Requests first seen at the same edge are ordered by channel number, with the lower number served first.

The grant is returned as a one-hot vector, a valid flag and the binary index of the granted channel. A grant covers exactly one packet. It stays in place until the engine reports that the packet is complete with a single-cycle done pulse. At that edge the grant moves directly to the next oldest pending request, or drops if nothing is waiting. A channel that asks again after being served queues behind every request already pending, so no channel can hold the engine.

Top module: `fcfs_chan_arbiter`

## Requirements
- R1: While reset is applied, and after its release until a request is seen, `gnt` is all zero, `gnt_valid` is 0 and `gnt_idx` is 0.
- R2: At most one bit of `gnt` is set. `gnt_valid` is 1 exactly when a bit is set, and `gnt_idx` then holds the binary position of that bit.
- R3: With no grant active, a request sampled high at one rising edge produces a grant visible after the second rising edge from that one.
- R4: Pending requests are granted in the order of the rising edge at which each was first sampled.
- R5: Requests first sampled at the same rising edge are granted lowest channel number first.
- R6: An active grant keeps the same `gnt` value until `pkt_done` is sampled high at a rising edge.
- R7: When `pkt_done` is sampled high during a grant, that same edge passes the grant to the oldest request pending before it. If no request is pending, the grant drops at that edge.
- R8: A channel's request is not registered while that channel holds the grant. A channel that requests again after being served is ordered behind every request already pending.
- R9: `pkt_done` sampled while no grant is active has no effect: no grant appears, and later requests follow R3.
- R10: The channel count is the parameter `NUM_CH`, default 12. Every channel index from 0 to 11 can be granted and reported on `gnt_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req | input | NUM_CH | Per-channel level request, held until granted |
| pkt_done | input | 1 | One-cycle pulse from the engine: the granted packet is complete |
| gnt | output | NUM_CH | One-hot grant |
| gnt_valid | output | 1 | A grant is active |
| gnt_idx | output | IDX_W (4) | Binary index of the granted channel |

## Verification
The assertions assume two things about the inputs. First, a channel holds its request high until it sees its own grant bit, and drops it before asking again. Second, `pkt_done` is only meaningful while a grant is active, so a stray pulse must leave the state untouched. The stimulus follows the same rules. Each channel's request is lowered in the cycle after its grant is observed. A new request is never raised for the channel currently granted, and every request is driven just after a falling edge, so the edge at which it is first sampled is known exactly. This lets the scoreboard predict the grant order and the cycle of each handoff from the arrival edges alone.

// File: rtl/fcfs_arb_pkg.sv
package fcfs_arb_pkg;

  // Index width for a channel count, never below one bit.
  function automatic int unsigned idx_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  typedef enum logic {
    GNT_IDLE = 1'b0,
    GNT_BUSY = 1'b1
  } gnt_state_e;

endpackage

// File: rtl/fcfs_rst_sync.sv
module fcfs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/fcfs_age_tracker.sv
// Pending set plus a pairwise "older than" matrix.
// age_q[i][j] = 1 means channel i's request predates channel j's.
module fcfs_age_tracker #(
  parameter int unsigned NUM_CH = 12
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] arrive,   // newly registered requests
  input  logic [NUM_CH-1:0] retire,   // channel granted at this edge
  output logic [NUM_CH-1:0] pending,
  output logic [NUM_CH-1:0] oldest
);

  logic [NUM_CH-1:0] pend_q, pend_d;
  logic [NUM_CH-1:0] age_q [NUM_CH];
  logic [NUM_CH-1:0] age_d [NUM_CH];
  logic              pend_en, age_en;

  // Next-state logic
  always_comb begin
    pend_d  = (pend_q & ~retire) | arrive;
    pend_en = |arrive | |retire;
    age_en  = |arrive;
    for (int i = 0; i < NUM_CH; i++) begin
      for (int j = 0; j < NUM_CH; j++) begin
        if (arrive[i])      age_d[i][j] = arrive[j] && (j > i);
        else if (arrive[j]) age_d[i][j] = pend_q[i];
        else                age_d[i][j] = age_q[i][j];
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      age_q  <= '{default: '0};
    end else begin
      if (pend_en) pend_q <= pend_d;
      if (age_en)  age_q  <= age_d;
    end
  end

  // A pending channel is oldest when no other pending channel predates it.
  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_pick
    logic [NUM_CH-1:0] beaten_by;
    always_comb begin
      for (int j = 0; j < NUM_CH; j++) beaten_by[j] = pend_q[j] & age_q[j][gi];
    end
    assign oldest[gi] = pend_q[gi] & ~(|beaten_by);
  end

  assign pending = pend_q;

  assert_pick_onehot_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(oldest));

  assert_pick_exists_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (|pend_q) |-> (|oldest));

  for (genvar ai = 0; ai < NUM_CH; ai++) begin : g_chk_row
    for (genvar aj = 0; aj < NUM_CH; aj++) begin : g_chk_col
      if (ai < aj) begin : g_tie
        assert_tie_low_first_R5: assert property (@(posedge clk) disable iff (!rst_ni)
          (arrive[ai] && arrive[aj]) |=> age_q[ai][aj]);
      end
      if (ai != aj) begin : g_behind
        assert_new_behind_pending_R8: assert property (@(posedge clk) disable iff (!rst_ni)
          (arrive[ai] && pend_q[aj] && !retire[aj]) |=> age_q[aj][ai]);
      end
    end
  end

endmodule

// File: rtl/fcfs_onehot_enc.sv
module fcfs_onehot_enc #(
  parameter int unsigned WIDTH = 12,
  parameter int unsigned IDX_W = 4
) (
  input  logic [WIDTH-1:0] onehot,
  output logic [IDX_W-1:0] index
);

  always_comb begin
    index = '0;
    for (int k = 0; k < WIDTH; k++) begin
      if (onehot[k]) index = index | IDX_W'(k);
    end
  end

endmodule

// File: rtl/fcfs_grant_reg.sv
module fcfs_grant_reg
  import fcfs_arb_pkg::*;
#(
  parameter int unsigned NUM_CH = 12
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] oldest,
  input  logic              any_pending,
  input  logic              pkt_done,
  output logic [NUM_CH-1:0] gnt,
  output logic              gnt_valid,
  output logic [NUM_CH-1:0] take
);

  gnt_state_e        state_q, state_d;
  logic [NUM_CH-1:0] gnt_q, gnt_d;
  logic              load, clear, upd_en;

  // Next-state logic
  always_comb begin
    load    = any_pending && ((state_q == GNT_IDLE) || pkt_done);
    clear   = (state_q == GNT_BUSY) && pkt_done && !any_pending;
    upd_en  = load || clear;
    gnt_d   = gnt_q;
    state_d = state_q;
    if (load) begin
      gnt_d   = oldest;
      state_d = GNT_BUSY;
    end else if (clear) begin
      gnt_d   = '0;
      state_d = GNT_IDLE;
    end
    take = load ? oldest : '0;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= GNT_IDLE;
      gnt_q   <= '0;
    end else if (upd_en) begin
      state_q <= state_d;
      gnt_q   <= gnt_d;
    end
  end

  assign gnt       = gnt_q;
  assign gnt_valid = (state_q == GNT_BUSY);

  assert_gnt_onehot_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(gnt_q));

  assert_gnt_held_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (gnt_valid && !pkt_done) |=> $stable(gnt_q));

  assert_handoff_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (gnt_valid && pkt_done && any_pending) |=> gnt_valid);

  assert_idle_done_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (!gnt_valid && !any_pending) |=> !gnt_valid);

endmodule

// File: rtl/fcfs_chan_arbiter.sv
module fcfs_chan_arbiter
  import fcfs_arb_pkg::*;
#(
  parameter int unsigned NUM_CH = 12,
  localparam int unsigned IDX_W = idx_w(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req,
  input  logic              pkt_done,
  output logic [NUM_CH-1:0] gnt,
  output logic              gnt_valid,
  output logic [IDX_W-1:0]  gnt_idx
);

  logic              rst_ni;
  logic [NUM_CH-1:0] pending, oldest, arrive, take;

  fcfs_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ni)
  );

  // A request registers once: not while pending, not while its channel holds the grant.
  assign arrive = req & ~pending & ~gnt;

  fcfs_age_tracker #(.NUM_CH(NUM_CH)) u_age (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .arrive  (arrive),
    .retire  (take),
    .pending (pending),
    .oldest  (oldest)
  );

  fcfs_grant_reg #(.NUM_CH(NUM_CH)) u_gnt (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .oldest      (oldest),
    .any_pending (|pending),
    .pkt_done    (pkt_done),
    .gnt         (gnt),
    .gnt_valid   (gnt_valid),
    .take        (take)
  );

  fcfs_onehot_enc #(.WIDTH(NUM_CH), .IDX_W(IDX_W)) u_enc (
    .onehot (gnt),
    .index  (gnt_idx)
  );

  assert_idx_matches_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    gnt_valid |-> (gnt == (NUM_CH'(1) << gnt_idx)));

  assert_no_grant_in_reset_R1: assert property (@(posedge clk)
    !rst_ni |-> (gnt == '0));

endmodule

// File: tb/tb_fcfs_chan_arbiter.sv
module tb_fcfs_chan_arbiter;

  localparam int NCH = 12;
  localparam int IW  = 4;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NCH-1:0] req;
  logic           done, stray;
  logic [NCH-1:0] gnt;
  logic           gnt_valid;
  logic [IW-1:0]  gnt_idx;

  int errors = 0;
  int checks = 0;
  int cyc    = 0;
  bit run    = 0;

  // scoreboard state
  int q_ch[$];
  int q_c[$];
  bit cur_valid = 0;
  int cur_idx   = 0;
  int hold      = 0;
  int done_c    = 0;
  bit just_done;

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  fcfs_chan_arbiter #(.NUM_CH(NCH)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .pkt_done  (done | stray),
    .gnt       (gnt),
    .gnt_valid (gnt_valid),
    .gnt_idx   (gnt_idx)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  // Driver: registers requests and pushes the expected grant order.
  task automatic raise(input logic [NCH-1:0] m);
    @(negedge clk); #1;
    for (int k = 0; k < NCH; k++) begin
      if (m[k] && !req[k] && !(cur_valid && cur_idx == k)) begin
        req[k] = 1'b1;
        q_ch.push_back(k);
        q_c.push_back(cyc);
      end
    end
  endtask

  task automatic wait_idle();
    int quiet = 0;
    while (quiet < 3) begin
      @(negedge clk); #2;
      if (q_ch.size() == 0 && !gnt_valid && !cur_valid) quiet++;
      else quiet = 0;
    end
  endtask

  // Monitor: compares each grant against the scoreboard and retires packets.
  always @(negedge clk) begin
    if (run) begin
      just_done = done;
      done = 1'b0;
      if (cur_valid && gnt_valid && !just_done) begin
        chk(gnt == (NCH'(1) << cur_idx), "R6 grant held", int'(gnt), 1 << cur_idx);
        hold--;
        if (hold <= 0) begin
          done   = 1'b1;
          done_c = cyc;
        end
      end else begin
        bit exp_v;
        if (just_done) exp_v = (q_ch.size() > 0) && (q_c[0] < done_c);
        else           exp_v = (q_ch.size() > 0) && (cyc - q_c[0] >= 2);
        if (just_done) chk(gnt_valid == exp_v, "R7 handoff valid", gnt_valid, exp_v);
        else           chk(gnt_valid == exp_v, "R3 grant latency", gnt_valid, exp_v);
        if (gnt_valid) begin
          int e;
          if (q_ch.size() == 0) begin
            chk(1'b0, "R4 unexpected grant", gnt_idx, -1);
            e = gnt_idx;
          end else begin
            e = q_ch.pop_front();
            void'(q_c.pop_front());
          end
          chk(gnt_idx == e, "R4 R5 R8 R10 grant order", gnt_idx, e);
          chk(gnt == (NCH'(1) << e), "R2 one-hot grant", int'(gnt), 1 << e);
          req[gnt_idx] = 1'b0;
          cur_valid = 1'b1;
          cur_idx   = gnt_idx;
          hold      = 1 + (cur_idx % 3);
        end else begin
          cur_valid = 1'b0;
        end
      end
    end
  end

  initial begin
    logic [15:0] lfsr;
    logic [NCH-1:0] m;
    rst_n = 1'b0;
    req   = '0;
    done  = 1'b0;
    stray = 1'b0;
    repeat (4) @(negedge clk);
    chk(gnt == '0 && !gnt_valid && gnt_idx == 0, "R1 reset state", int'(gnt), 0);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(gnt == '0 && !gnt_valid && gnt_idx == 0, "R1 after release", int'(gnt), 0);
    end
    run = 1;

    // R3: single request from idle
    raise(NCH'(1) << 4);
    wait_idle();

    // R5 R10: all twelve at once, expect 0..11
    raise('1);
    wait_idle();

    // R4: staggered arrivals -> 9, 2, 0, 6
    raise(NCH'(1) << 9);
    raise(NCH'(1) << 2);
    raise((NCH'(1) << 6) | NCH'(1));
    wait_idle();

    // R8: channel 3 re-requests while 8 is still pending -> 3, 5, 8, 3
    raise((NCH'(1) << 3) | (NCH'(1) << 5) | (NCH'(1) << 8));
    while (!(cur_valid && cur_idx == 5)) begin @(negedge clk); #2; end
    raise(NCH'(1) << 3);
    wait_idle();

    // R9: stray done while idle, then a normal request
    @(negedge clk); #1 stray = 1'b1;
    @(negedge clk); #1 stray = 1'b0;
    @(negedge clk); #2;
    chk(!gnt_valid && gnt == '0, "R9 stray done ignored", gnt_valid, 0);
    raise(NCH'(1) << 7);
    wait_idle();

    // R7: pair, handoff at the retiring edge
    raise((NCH'(1) << 10) | (NCH'(1) << 1));
    wait_idle();

    // Mixed traffic
    lfsr = 16'hACE1;
    for (int it = 0; it < 60; it++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      m = lfsr[NCH-1:0] & lfsr[NCH+3:4];
      raise(m);
      repeat (int'(lfsr[2:0])) @(negedge clk);
    end
    wait_idle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule